// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit single-precision operands and returns their product in the same packed layout: one sign bit, an 8-bit biased exponent and a 23-bit fraction. The product is valid one clock after an accepted request, together with an overflow flag and an underflow flag. A request is accepted only when `req_valid` is high and the operation selector carries the multiply code 3'b010. Any other code leaves the block idle, so a shared operation bus can feed it directly.

The sign is the exclusive-OR of the operand signs. The biased exponents are added and one bias of 127 is removed, in a 10-bit signed intermediate so that out-of-range results are visible before packing. The two 24-bit significands, with their hidden ones, are multiplied into a 48-bit product. That product is normalised by at most one place, and the fraction is truncated with no rounding. A zero operand yields a signed zero with no flag raised. NaN, infinity, subnormal operands and rounding modes other than truncation are not handled.

Top module: `fp32_mul`

## Requirements
- R1: The result sign (bit 31) equals the exclusive-OR of bit 31 of the two operands, including for zero results.
- R2: When bit 47 of the 48-bit significand product is clear, the result exponent field (bits 30:23) is ea + eb - 127 and the fraction (bits 22:0) is product bits 45..23.
- R3: When bit 47 of the significand product is set, the result exponent is ea + eb - 127 + 1 and the fraction is product bits 46..24.
- R4: Low product bits below the kept fraction are discarded with no rounding, even when they exceed half of one unit in the last place.
- R5: `flag_unf` is raised when the final 10-bit signed exponent (after the normalisation increment) is below 1. The packed exponent field is then the low 8 bits of that value.
- R6: `flag_ovf` is raised when the final exponent is above 254. The packed exponent field is then the low 8 bits of that value.
- R7: If either operand has exponent 0 and fraction 0, the result is {sign, 31'b0}, and neither flag is raised.
- R8: A request with `req_valid` high and `op_sel` other than 3'b010 is ignored: `res_valid` stays low in the next cycle.
- R9: An accepted request gives `res_valid` high exactly one cycle later. In any cycle where `res_valid` is low, both flags are low. The two flags are never high together.
- R10: During and after reset, and before any request, `res_valid`, `res_word`, `flag_ovf` and `flag_unf` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation selector; 3'b010 selects multiply |
| opnd_a | input | 32 | First operand, packed single precision |
| opnd_b | input | 32 | Second operand, packed single precision |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| res_word | output | 32 | Packed product |
| flag_ovf | output | 1 | Biased exponent above 254 |
| flag_unf | output | 1 | Biased exponent below 1 |

## Verification
The normalisation increment and the range check land in the same cycle, because the increment can push the exponent over a limit or pull it back inside one. The bench drives operand pairs whose exponent sum sits at 254 or at 0, with significands of 1.0 and of 1.5. A 1.5 x 1.5 pair sets bit 47, while 1.0 leaves it clear. The same sum then overflows in one case and not in the other, and underflows in one case and not in the other. Each result is judged against a reference model built from the requirements. The model applies the increment before the bounds are compared.

// File: rtl/fp32_mul.sv
module fp32_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter logic [2:0] MUL_CODE = 3'b010
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  op_sel,
  input  logic [EXP_W+FRAC_W:0]       opnd_a,
  input  logic [EXP_W+FRAC_W:0]       opnd_b,
  output logic                        res_valid,
  output logic [EXP_W+FRAC_W:0]       res_word,
  output logic                        flag_ovf,
  output logic                        flag_unf
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int PROD_W = 2 * MANT_W;
  localparam int EI_W   = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 2;

  logic                     accept;
  logic                     sgn;
  logic [EXP_W-1:0]         ea, eb;
  logic [MANT_W-1:0]        ma, mb;
  logic [PROD_W-1:0]        prod;
  logic                     top;
  logic signed [EI_W-1:0]   esum;
  logic [FRAC_W-1:0]        frac;
  logic                     is_zero;
  logic                     ovf, unf;
  logic [WORD_W-1:0]        packed_w;

  assign accept  = req_valid && (op_sel == MUL_CODE);
  assign sgn     = opnd_a[WORD_W-1] ^ opnd_b[WORD_W-1];
  assign ea      = opnd_a[WORD_W-2:FRAC_W];
  assign eb      = opnd_b[WORD_W-2:FRAC_W];
  assign ma      = {1'b1, opnd_a[FRAC_W-1:0]};
  assign mb      = {1'b1, opnd_b[FRAC_W-1:0]};
  assign prod    = ma * mb;
  assign top     = prod[PROD_W-1];
  assign is_zero = (opnd_a[WORD_W-2:0] == '0) || (opnd_b[WORD_W-2:0] == '0);

  assign esum = $signed({2'b00, ea}) + $signed({2'b00, eb})
              - $signed(EI_W'(BIAS)) + $signed({{(EI_W-1){1'b0}}, top});

  assign frac = top ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];

  assign ovf = !is_zero && (esum > $signed(EI_W'(EMAX)));
  assign unf = !is_zero && (esum < $signed(EI_W'(1)));

  assign packed_w = is_zero ? {sgn, {(WORD_W-1){1'b0}}}
                            : {sgn, esum[EXP_W-1:0], frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
    end else begin
      res_valid <= accept;
      flag_ovf  <= accept && ovf;
      flag_unf  <= accept && unf;
      if (accept) res_word <= packed_w;
    end
  end
endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  op_sel,
  input logic [31:0] opnd_a,
  input logic [31:0] opnd_b,
  input logic        res_valid,
  input logic [31:0] res_word,
  input logic        flag_ovf,
  input logic        flag_unf
);
  logic acc;
  assign acc = req_valid && (op_sel == 3'b010);

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_word[31] == ($past(opnd_a[31]) ^ $past(opnd_b[31]))); // R1

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (opnd_a[30:0] == 31'd0 || opnd_b[30:0] == 31'd0))
      |=> res_word[30:0] == 31'd0 && !flag_ovf && !flag_unf); // R7

  AST_IGNORE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel != 3'b010) |=> !res_valid); // R8

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid); // R9

  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !flag_ovf && !flag_unf); // R9

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_ovf, flag_unf}) <= 1); // R9

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(res_word)); // R9
endmodule

bind fp32_mul fp32_mul_chk u_fp32_mul_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_sel(op_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
  .res_word(res_word), .flag_ovf(flag_ovf), .flag_unf(flag_unf));

// File: tb/test_fp32_mul.sv
module test_fp32_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op_sel = 3'b000;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        res_valid;
  logic [31:0] res_word;
  logic        flag_ovf, flag_unf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fp32_mul i_fp32_mul (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .res_word(res_word), .flag_ovf(flag_ovf), .flag_unf(flag_unf));

  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [47:0] p;
    int e;
    logic [22:0] f;
    logic s;
    s = a[31] ^ b[31];
    if (a[30:0] == 0 || b[30:0] == 0) return {1'b0, 1'b0, s, 31'd0};
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin e = e + 1; f = p[46:24]; end
    else f = p[45:23];
    return {(e > 254), (e < 1), s, e[7:0], f};
  endfunction

  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    @(negedge clk);
    req_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
    if (v && op == 3'b010) exp_q.push_back({1'b1, model(a, b)});
    else exp_q.push_back(35'd0);
    tag_q.push_back(tag);
  endtask

  task automatic mul(input logic [31:0] a, input logic [31:0] b, input string tag);
    step(1'b1, 3'b010, a, b, tag);
  endtask

  initial begin : monitor
    @(posedge rst_n);
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() != 0) begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (e[34]) begin
          if (!res_valid || res_word !== e[31:0] || flag_ovf !== e[33] || flag_unf !== e[32]) begin
            n_fail++;
            $display("FAIL %s: v=%0b word=%h ovf=%0b unf=%0b exp v=1 word=%h ovf=%0b unf=%0b",
                     t, res_valid, res_word, flag_ovf, flag_unf, e[31:0], e[33], e[32]);
          end
        end else if (res_valid || flag_ovf || flag_unf) begin
          n_fail++;
          $display("FAIL %s: v=%0b ovf=%0b unf=%0b exp all 0", t, res_valid, flag_ovf, flag_unf);
        end
      end else if (res_valid) begin
        n_chk++; n_fail++;
        $display("FAIL R8: unexpected res_valid=1 exp 0");
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: done=0 exp 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    #3;
    n_chk++;
    if (res_valid !== 1'b0 || res_word !== 32'd0 || flag_ovf !== 1'b0 || flag_unf !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: v=%0b word=%h ovf=%0b unf=%0b exp 0", res_valid, res_word, flag_ovf, flag_unf);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'b010, 32'd0, 32'd0, "R10_idle");
    n_chk++;
    if (res_word !== 32'd0) begin
      n_fail++;
      $display("FAIL R10: word=%h exp 00000000", res_word);
    end

    mul(32'h3F800000, 32'h3F800000, "R2_one");
    mul(32'h3FC00000, 32'h3FC00000, "R3_norm");
    mul(32'hC0000000, 32'h40400000, "R1_neg");
    mul(32'hBFC00000, 32'hC0400000, "R1_negneg");
    mul(32'h3F800001, 32'h3F800001, "R4_trunc_a");
    mul(32'h3FC00001, 32'h3FC00001, "R4_trunc_b");
    mul(32'h3FFFFFFF, 32'h3FFFFFFF, "R4_trunc_c");
    mul(32'h7F000000, 32'h40000000, "R6_ovf");
    mul(32'h7F400000, 32'h3F800000, "R6_edge_ok");
    mul(32'h7F400000, 32'h3FC00000, "R6_edge_norm");
    mul(32'h00800000, 32'h00800000, "R5_unf");
    mul(32'h1F800000, 32'h20000000, "R5_edge_zero");
    mul(32'h1FC00000, 32'h20400000, "R5_edge_norm");
    mul(32'h00000000, 32'h7F000000, "R7_zero_a");
    mul(32'h80000000, 32'h3F800000, "R7_negzero");
    mul(32'h3F800000, 32'h80000000, "R7_zero_b");
    step(1'b1, 3'b011, 32'h3F800000, 32'h3F800000, "R8_op011");
    step(1'b1, 3'b000, 32'h7F000000, 32'h7F000000, "R8_op000");
    step(1'b0, 3'b010, 32'h00800000, 32'h00800000, "R9_novalid");
    mul(32'h40000000, 32'h40000000, "R9_back1");
    mul(32'h7F000000, 32'h7F000000, "R9_back2");
    mul(32'h00800000, 32'h3F000000, "R9_back3");
    step(1'b0, 3'b000, 32'd0, 32'd0, "R9_idle");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      a[30:23] = 8'(1 + ($urandom % 254));
      b[30:23] = 8'(1 + ($urandom % 254));
      mul(a, b, (i % 2) ? "R2_R3_rand" : "R5_R6_rand");
    end
    step(1'b0, 3'b000, 32'd0, 32'd0, "R9_tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule